// File: doc/BRIEF.md
# Strobe-Handshake Register Port

This block is the slave side of an 8-bit microprocessor register bus that uses a data strobe and an acknowledge, both active low. The host sets the address and the read/write select, pulls the strobe low, and waits for acknowledge before it takes read data from the shared data bus. The block samples the strobe in its own reference clock domain and passes each access to an internal register file port. It asserts acknowledge once the data is ready.

Two kinds of register sit behind the port. Plain status registers return data at once. Counter registers need a snapshot request first, so they take one extra clock. The upper part of the address space holds the counters. After each access the block enforces a recovery gap of a fixed number of clocks, and it ignores any strobe that falls inside that gap. A host that holds the strobe low for 4.5 clocks can read any register without watching acknowledge.

Top module: `ubus_reg_port`

## Requirements
- R1: While reset is held and directly after it, `ack_n` is high, `rf_we` and `rf_re` are low, and the block does not drive `bus_data`.
- R2: An access starts only when the strobe, after a two-flop synchronizer, goes from high to low. A strobe that is already low when the block becomes idle starts nothing until it has gone high and fallen again.
- R3: For an address below `CNT_BASE` (a status register, one clock of latency), `ack_n` falls on the third rising clock edge after a strobe fall that lands between edges.
- R4: For an address at or above `CNT_BASE` (a counter), `rf_re` pulses for one clock in the cycle the read is accepted. `ack_n` falls on the fourth rising edge after the strobe fall, and the returned data is the value the register file gives one clock after that request.
- R5: During a read, `bus_data` carries the returned register value while `ack_n` is low and `strobe_n` is low. At all other times the block releases the bus.
- R6: `ack_n` stays low until the synchronized strobe is high. It rises on the third rising edge after the strobe rises.
- R7: A write captures `bus_data` when it is accepted. `rf_we` pulses for exactly the clock in which `ack_n` first reads low, with `rf_addr` and `rf_wdata` holding the access address and the captured data. The acknowledge latency is the same as for a read of that address.
- R8: A strobe that falls fewer than `RECOV_CYC` (7) clocks after the previous strobe rose is ignored: no acknowledge and no register file request, even if the strobe is held low. A strobe that falls exactly `RECOV_CYC` clocks after the rise is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_n | input | 1 | Data strobe from the host, active low, asynchronous |
| rd_wr | input | 1 | 1 = read, 0 = write; stable while the strobe is low |
| addr | input | ADDR_W | Register address; stable while the strobe is low |
| bus_data | inout | DATA_W | Shared bidirectional data bus |
| ack_n | output | 1 | Acknowledge to the host, active low |
| rf_addr | output | ADDR_W | Register file address |
| rf_re | output | 1 | Read request pulse (loads counter snapshots) |
| rf_we | output | 1 | Write commit pulse |
| rf_wdata | output | DATA_W | Write data to the register file |
| rf_rdata | input | DATA_W | Read data from the register file |

## Verification
The bench checks acknowledge one clock before and at its expected edge for both latency classes. A design that got the counter latency wrong would return the stale snapshot or acknowledge early. The bench drops a strobe six clocks after a release and holds it low. A recovery window that is off by one would accept it, and an edge detector that acts on the strobe level would accept it once the window closed. Write-back through a later read catches a write committed on the wrong cycle or with data captured at the wrong time.

// File: rtl/ubus_reg_port_pkg.sv
// Package: types shared by the register port modules.
// Assumes: nothing beyond IEEE 1800-2017.
package ubus_reg_port_pkg;

    // Access sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ACK   = 2'd2,
        ST_RECOV = 2'd3
    } port_state_t;

    // Smallest recovery gap the sequencer can express: synchronizer delay plus one.
    localparam int MIN_RECOV = 3;

endpackage

// File: rtl/ubus_strobe_sync.sv
// Module: ubus_strobe_sync
// Brings the asynchronous active-low strobe into the clock domain through a
// chain of STAGES flops. It gives the synchronized level and a one-cycle flag
// for a high-to-low transition of that level.
// Assumes: STAGES >= 2; the idle strobe level is high, so reset fills with 1.
module ubus_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic strb_hi,
    output logic strb_fall
);

    logic [STAGES-1:0] chain;
    logic              last_hi;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage variant: capture the raw strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= strobe_n;
            end
        end else begin : g_multi
            // Multi-stage variant: shift the raw strobe through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], strobe_n};
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_hi <= 1'b1;
        else        last_hi <= chain[STAGES-1];
    end

    assign strb_hi   = chain[STAGES-1];
    assign strb_fall = last_hi & ~chain[STAGES-1];

endmodule

// File: rtl/ubus_lat_map.sv
// Module: ubus_lat_map
// Sorts an address into a latency class. Addresses at or above CNT_BASE are
// counters that need a snapshot cycle; the rest are plain status registers.
// Assumes: CNT_BASE may equal 2**ADDR_W, which means no counters at all.
module ubus_lat_map #(
    parameter int ADDR_W   = 6,
    parameter int CNT_BASE = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              slow
);

    localparam logic [ADDR_W:0] BASE_EXT = (ADDR_W+1)'(CNT_BASE);

    generate
        if (CNT_BASE >= (1 << ADDR_W)) begin : g_no_counters
            // Every register is a status register.
            logic unused_addr;
            assign unused_addr = ^addr;
            assign slow        = 1'b0;
        end else begin : g_split
            // Compare against the base of the counter region.
            assign slow = ({1'b0, addr} >= BASE_EXT);
        end
    endgenerate

endmodule

// File: rtl/ubus_access_fsm.sv
// Module: ubus_access_fsm
// Sequences one access: accepts a synchronized strobe fall while idle, waits
// the per-register latency, captures read data or commits a write, holds
// acknowledge until the strobe is released, and then enforces the recovery gap.
// Assumes: address, direction and write data are stable from strobe fall
// until acknowledge; RECOV_CYC >= MIN_RECOV.
module ubus_access_fsm
    import ubus_reg_port_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int RECOV_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_hi,
    input  logic              strb_fall,
    input  logic              rd_wr,
    input  logic              slow,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              ack_n,
    output logic              accept,
    output logic              rd_drive,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_re,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata
);

    // Two synchronizer clocks pass before the state machine sees the release.
    localparam int RECOV_LOAD = RECOV_CYC - 2;
    localparam int CNT_W      = (RECOV_LOAD < 2) ? 1 : $clog2(RECOV_LOAD + 1);

    port_state_t       state;
    logic [CNT_W-1:0]  gap_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              rd_q;

    // Accept a new access only from idle and only on a strobe edge.
    assign accept   = (state == ST_IDLE) && strb_fall;
    assign rf_re    = accept && rd_wr;
    assign rf_addr  = (state == ST_IDLE) ? addr : addr_q;
    assign rf_wdata = wdata_q;
    assign rd_drive = (state == ST_ACK) && rd_q;

    // Main sequencer: latency, capture or commit, hold, recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ack_n   <= 1'b1;
            rf_we   <= 1'b0;
            gap_cnt <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rd_q    <= 1'b0;
            rd_data <= '0;
        end else begin
            rf_we <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q  <= addr;
                        rd_q    <= rd_wr;
                        wdata_q <= bus_in;
                        if (slow) begin
                            state <= ST_WAIT;
                        end else begin
                            state <= ST_ACK;
                            ack_n <= 1'b0;
                            if (rd_wr) rd_data <= rf_rdata;
                            else       rf_we   <= 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    state <= ST_ACK;
                    ack_n <= 1'b0;
                    if (rd_q) rd_data <= rf_rdata;
                    else      rf_we   <= 1'b1;
                end
                ST_ACK: begin
                    if (strb_hi) begin
                        state   <= ST_RECOV;
                        ack_n   <= 1'b1;
                        gap_cnt <= CNT_W'(RECOV_LOAD);
                    end
                end
                ST_RECOV: begin
                    if (gap_cnt == '0) state <= ST_IDLE;
                    else               gap_cnt <= gap_cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ubus_reg_port.sv
// Module: ubus_reg_port (top)
// Register access slave for a strobe/acknowledge microprocessor bus. It ties
// together the strobe synchronizer, the latency map and the access sequencer,
// and drives the shared data bus only while a read is acknowledged and the
// strobe is still low.
// Assumes: a single reference clock; the host respects the acknowledge.
module ubus_reg_port
    import ubus_reg_port_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int CNT_BASE    = 32,
    parameter int SYNC_STAGES = 2,
    parameter int RECOV_CYC   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [DATA_W-1:0] bus_data,
    output logic              ack_n,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_re,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);

    logic              strb_hi_w;
    logic              strb_fall_w;
    logic              slow_w;
    logic              accept_w;
    logic              rd_drive_w;
    logic              bus_oe;
    logic [DATA_W-1:0] rd_data_w;

    ubus_strobe_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_n  (strobe_n),
        .strb_hi   (strb_hi_w),
        .strb_fall (strb_fall_w)
    );

    ubus_lat_map #(
        .ADDR_W   (ADDR_W),
        .CNT_BASE (CNT_BASE)
    ) u_lat (
        .addr (addr),
        .slow (slow_w)
    );

    ubus_access_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .RECOV_CYC (RECOV_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_hi   (strb_hi_w),
        .strb_fall (strb_fall_w),
        .rd_wr     (rd_wr),
        .slow      (slow_w),
        .addr      (addr),
        .bus_in    (bus_data),
        .rf_rdata  (rf_rdata),
        .ack_n     (ack_n),
        .accept    (accept_w),
        .rd_drive  (rd_drive_w),
        .rd_data   (rd_data_w),
        .rf_addr   (rf_addr),
        .rf_re     (rf_re),
        .rf_we     (rf_we),
        .rf_wdata  (rf_wdata)
    );

    // Release the bus at once when the raw strobe rises.
    assign bus_oe   = rd_drive_w && !strobe_n;
    assign bus_data = bus_oe ? rd_data_w : {DATA_W{1'bz}};

endmodule

// File: rtl/ubus_reg_port_chk.sv
// Module: ubus_reg_port_chk
// Assertion checker bound to ubus_reg_port. It watches the handshake, the
// register file pulses and the recovery gap.
// Assumes: reset is synchronous and active low.
module ubus_reg_port_chk #(
    parameter int RECOV_CYC = 7
) (
    input logic clk,
    input logic rst_n,
    input logic ack_n,
    input logic rf_re,
    input logic rf_we,
    input logic accept,
    input logic bus_oe,
    input logic strb_hi
);

    logic [7:0] since_rel;

    // Count clocks since acknowledge was last seen low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)            since_rel <= 8'hff;
        else if (!ack_n)       since_rel <= 8'd0;
        else if (since_rel != 8'hff) since_rel <= since_rel + 8'd1;
    end

    assert_quiet_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (ack_n && !rf_we));

    assert_start_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($past(strb_hi) && !strb_hi));

    assert_ack_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> ($past(accept, 1) || $past(accept, 2)));

    assert_drive_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !ack_n);

    assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !strb_hi) |=> !ack_n);

    assert_write_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (!ack_n && $past(ack_n)));

    assert_recovery_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (int'(since_rel) >= RECOV_CYC - 1));

    assert_one_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_re, rf_we}));

endmodule

bind ubus_reg_port ubus_reg_port_chk #(
    .RECOV_CYC (RECOV_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_n   (ack_n),
    .rf_re   (rf_re),
    .rf_we   (rf_we),
    .accept  (accept_w),
    .bus_oe  (bus_oe),
    .strb_hi (strb_hi_w)
);

// File: tb/ubus_reg_port_test.sv
// Bench: directed scenarios against ubus_reg_port with a behavioural
// register file (32 status registers, a counter snapshot above them).
module ubus_reg_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_n = 1'b1;
    logic       rd_wr = 1'b1;
    logic [5:0] addr = '0;
    logic       tb_drv = 1'b0;
    logic [7:0] tb_d = '0;
    wire  [7:0] bus;
    logic       ack_n;
    logic [5:0] rf_addr;
    logic       rf_re;
    logic       rf_we;
    logic [7:0] rf_wdata;
    logic [7:0] rf_rdata;

    logic [7:0] stat [32];
    logic [7:0] snap;
    logic [7:0] cnt_src;
    int         n_checks = 0;
    int         n_fails = 0;
    bit         done = 0;

    assign bus = tb_drv ? tb_d : 8'hzz;

    always #10 clk = ~clk;

    ubus_reg_port uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .rd_wr    (rd_wr),
        .addr     (addr),
        .bus_data (bus),
        .ack_n    (ack_n),
        .rf_addr  (rf_addr),
        .rf_re    (rf_re),
        .rf_we    (rf_we),
        .rf_wdata (rf_wdata),
        .rf_rdata (rf_rdata)
    );

    // Register file model: status array plus a counter snapshot loaded on rf_re.
    assign rf_rdata = rf_addr[5] ? snap : stat[rf_addr[4:0]];
    always @(posedge clk) begin
        if (rf_we && !rf_addr[5]) stat[rf_addr[4:0]] <= rf_wdata;
        if (rf_re) snap <= cnt_src;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One full access with timing checks; returns six clocks after release.
    task automatic run_access(input bit rd, input logic [5:0] a,
                              input logic [7:0] wd, input logic [7:0] exp);
        int lat = (a >= 6'd32) ? 2 : 1;
        @(negedge clk);
        addr = a; rd_wr = rd; tb_d = wd; tb_drv = !rd; strobe_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(rf_re == rd, "R4", "read request in accept cycle", rf_re, rd);
        check(ack_n == 1'b1, lat == 1 ? "R3" : "R4", "ack one clock early", ack_n, 1);
        if (lat == 2) begin
            @(posedge clk); @(negedge clk);
            check(ack_n == 1'b1, "R4", "counter ack one clock early", ack_n, 1);
        end
        @(posedge clk); @(negedge clk);
        check(ack_n == 1'b0, lat == 1 ? "R3" : "R4", "ack at expected edge", ack_n, 0);
        if (rd) begin
            check(bus == exp, "R5", "read data on bus", bus, exp);
        end else begin
            check(rf_we == 1'b1 && rf_addr == a && rf_wdata == wd, "R7",
                  "write commit with ack", {rf_we, rf_addr, rf_wdata}, {1'b1, a, wd});
        end
        strobe_n = 1'b1; tb_drv = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(ack_n == 1'b0, "R6", "ack held through sync", ack_n, 0);
        @(negedge clk);
        check(ack_n == 1'b1, "R6", "ack released", ack_n, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(ack_n && !rf_we && !rf_re, "R1", "quiet during reset",
              {ack_n, rf_we, rf_re}, 3'b100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ack_n && !rf_we && !rf_re, "R1", "quiet after reset",
              {ack_n, rf_we, rf_re}, 3'b100);
    endtask

    task automatic t_status();
        run_access(1'b0, 6'd3, 8'hA5, 8'h00);
        run_access(1'b0, 6'd0, 8'h3C, 8'h00);
        run_access(1'b0, 6'd31, 8'h81, 8'h00);
        run_access(1'b1, 6'd3, 8'h00, 8'hA5);
        run_access(1'b1, 6'd0, 8'h00, 8'h3C);
        run_access(1'b1, 6'd31, 8'h00, 8'h81);
    endtask

    task automatic t_counter();
        cnt_src = 8'h5A;
        run_access(1'b1, 6'd40, 8'h00, 8'h5A);
        cnt_src = 8'hC3;
        run_access(1'b1, 6'd63, 8'h00, 8'hC3);
        run_access(1'b0, 6'd33, 8'h77, 8'h00);
    endtask

    // Strobe falls six clocks after release and is held: must be ignored.
    task automatic t_early(input bit rd);
        int bad = 0;
        run_access(rd, 6'd5, 8'h11, rd ? stat[5] : 8'h00);
        addr = 6'd5; rd_wr = rd; strobe_n = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!ack_n || rf_re || rf_we) bad++;
        end
        check(bad == 0, "R8", "early strobe ignored", bad, 0);
        check(bad == 0, "R2", "held-low strobe starts nothing", bad, 0);
        strobe_n = 1'b1;
        repeat (9) @(negedge clk);
        run_access(1'b1, 6'd5, 8'h00, 8'h11);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) stat[i] = 8'h00;
        snap = 8'h00;
        cnt_src = 8'h00;
        t_reset();
        t_status();
        t_counter();
        t_early(1'b0);
        t_early(1'b1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule